// File: doc/BRIEF.md
# Inline Byte-String Mismatch Comparator

This block runs the byte-string comparison behind a "branch if not equal" instruction of a packet filter engine. The literal bytes to compare sit inline in the program, directly after the instruction's two immediates. The first immediate is the branch offset and the second is the byte count. The packet bytes start at an offset held in whichever register the instruction's register bit selects. The caller has already decoded the instruction. It gives the block the program address of the first literal byte, the packet start offset and the count, and then waits for a done pulse.

The block reads one literal byte and one packet byte per cycle through two asynchronous byte read ports. It stops at the first byte that differs. A set mismatch flag means the branch is taken. The block also checks the requested span against the packet length before any byte is read. It reports the program address just past the literal bytes, so that the caller can resume fetching there when the branch falls through. Computing the branch target and updating the program counter are left to the caller.

Top module: `seqcmp_unit`

## Requirements
- R1: After reset, done_o, busy_o, mismatch_o and oob_o are all 0 and next_addr_o is 0.
- R2: While walking, in the k-th busy cycle after the start cycle (k = 1, 2, ...), prog_rd_addr_o equals (lit_addr_i + k - 1) mod 2^PROG_AW and pkt_rd_addr_o equals pkt_off_i + k - 1. One byte pair is read per cycle.
- R3: When all N literal bytes equal the N packet bytes, done_o rises N+1 cycles after the start cycle, with mismatch_o = 0 and oob_o = 0.
- R4: When the first differing byte is at index j (0-based), the walk stops there. done_o rises j+2 cycles after the start cycle, with mismatch_o = 1 and oob_o = 0.
- R5: When pkt_off_i + N > pkt_len_i (computed without wrap-around), done_o rises one cycle after the start cycle with oob_o = 1 and mismatch_o = 0, and busy_o never rises. A span ending exactly at pkt_len_i is in bounds.
- R6: A count of zero gives done_o one cycle after the start cycle, with mismatch_o = 0 and oob_o = 0.
- R7: At done_o, next_addr_o equals (lit_addr_i + N) mod 2^PROG_AW for the accepted request. It and the two flags hold their values until the next done_o.
- R8: A start_i pulse while busy_o is high is ignored. The running comparison keeps its captured operands and finishes with its own result and latency.
- R9: done_o is high for exactly one cycle per accepted request and never in the same cycle as busy_o. busy_o is high from the cycle after the start cycle until the cycle before done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, accepted when not busy |
| lit_addr_i | input | PROG_AW | Program address of the first literal byte |
| pkt_off_i | input | OFF_W | Packet start offset (selected register value) |
| cnt_i | input | CNT_W | Number of bytes to compare |
| pkt_len_i | input | OFF_W | Packet length in bytes |
| prog_rd_addr_o | output | PROG_AW | Program byte read address |
| prog_rd_data_i | input | 8 | Program byte, same-cycle read data |
| pkt_rd_addr_o | output | OFF_W | Packet byte read address |
| pkt_rd_data_i | input | 8 | Packet byte, same-cycle read data |
| busy_o | output | 1 | Comparison walk in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mismatch_o | output | 1 | Sequences differ (branch taken) |
| oob_o | output | 1 | Requested span exceeds packet length |
| next_addr_o | output | PROG_AW | Program address just past the literal bytes |

## Verification
A wrong byte index or base register shows up on the read address ports in the same cycle, so it is caught long before any result appears. A stuck or skipped compare, or a missed early stop, changes the done latency: a lost first mismatch appears as a late done with the wrong flag, in the cycle where the early stop should have finished. A bounds error shows as a walk that starts where none should, or as oob_o on an in-bounds span, one cycle after start. A start accepted during a walk shows as changed addresses in the very next cycle.

// File: rtl/seqcmp_pkg.sv
package seqcmp_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WALK = 1'b1
  } seq_state_e;

  // Span end past packet end; operands zero-extended by the caller.
  function automatic logic span_exceeds(input logic [63:0] off,
                                        input logic [63:0] cnt,
                                        input logic [63:0] len);
    return (off + cnt) > len;
  endfunction

  function automatic logic bytes_differ(input logic [7:0] a,
                                        input logic [7:0] b);
    return a != b;
  endfunction

endpackage

// File: rtl/seqcmp_bounds.sv
module seqcmp_bounds #(
  parameter int OFF_W = 32,
  parameter int CNT_W = 16
) (
  input  logic [OFF_W-1:0] off_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [OFF_W-1:0] len_i,
  output logic             oob_o,
  output logic             empty_o
);
  import seqcmp_pkg::*;

  always_comb begin
    oob_o   = span_exceeds(64'(off_i), 64'(cnt_i), 64'(len_i));
    empty_o = (cnt_i == '0);
  end

endmodule

// File: rtl/seqcmp_walker.sv
module seqcmp_walker #(
  parameter int PROG_AW = 10,
  parameter int OFF_W   = 32,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic               step_i,
  input  logic [PROG_AW-1:0] lit_i,
  input  logic [OFF_W-1:0]   off_i,
  input  logic [CNT_W-1:0]   cnt_i,
  output logic [PROG_AW-1:0] prog_addr_o,
  output logic [OFF_W-1:0]   pkt_addr_o,
  output logic               last_o
);
  logic [PROG_AW-1:0] prog_q;
  logic [OFF_W-1:0]   pkt_q;
  logic [CNT_W-1:0]   remain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog_q   <= '0;
      pkt_q    <= '0;
      remain_q <= '0;
    end else if (load_i) begin
      prog_q   <= lit_i;
      pkt_q    <= off_i;
      remain_q <= cnt_i;
    end else if (step_i) begin
      prog_q   <= prog_q + PROG_AW'(1);
      pkt_q    <= pkt_q + OFF_W'(1);
      remain_q <= remain_q - CNT_W'(1);
    end
  end

  assign prog_addr_o = prog_q;
  assign pkt_addr_o  = pkt_q;
  assign last_o      = (remain_q == CNT_W'(1));

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(step_i) && !$past(load_i) |->
      (prog_addr_o == $past(prog_addr_o) + PROG_AW'(1)) &&
      (pkt_addr_o == $past(pkt_addr_o) + OFF_W'(1)));

endmodule

// File: rtl/seqcmp_result.sv
module seqcmp_result #(
  parameter int PROG_AW = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               finish_i,
  input  logic               mis_i,
  input  logic               oob_i,
  input  logic [PROG_AW-1:0] next_i,
  output logic               done_o,
  output logic               mismatch_o,
  output logic               oob_o,
  output logic [PROG_AW-1:0] next_addr_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_o      <= 1'b0;
      mismatch_o  <= 1'b0;
      oob_o       <= 1'b0;
      next_addr_o <= '0;
    end else begin
      done_o <= finish_i;
      if (finish_i) begin
        mismatch_o  <= mis_i;
        oob_o       <= oob_i;
        next_addr_o <= next_i;
      end
    end
  end

  // R7
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(mismatch_o) && $stable(oob_o) && $stable(next_addr_o));

endmodule

// File: rtl/seqcmp_unit.sv
module seqcmp_unit #(
  parameter int PROG_AW = 10,
  parameter int OFF_W   = 32,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [PROG_AW-1:0] lit_addr_i,
  input  logic [OFF_W-1:0]   pkt_off_i,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic [OFF_W-1:0]   pkt_len_i,
  output logic [PROG_AW-1:0] prog_rd_addr_o,
  input  logic [7:0]         prog_rd_data_i,
  output logic [OFF_W-1:0]   pkt_rd_addr_o,
  input  logic [7:0]         pkt_rd_data_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               mismatch_o,
  output logic               oob_o,
  output logic [PROG_AW-1:0] next_addr_o
);
  import seqcmp_pkg::*;

  localparam int SUM_W = ((PROG_AW > CNT_W) ? PROG_AW : CNT_W) + 1;

  seq_state_e         state_q;
  logic [PROG_AW-1:0] next_q;
  logic [SUM_W-1:0]   end_sum;
  logic [PROG_AW-1:0] next_c;

  // Named internal events
  logic accept;
  logic span_oob;
  logic span_empty;
  logic instant_end;
  logic byte_diff;
  logic last_byte;
  logic walk_end;
  logic finish;
  logic fin_mis;
  logic fin_oob;
  logic [PROG_AW-1:0] fin_next;

  seqcmp_bounds #(.OFF_W(OFF_W), .CNT_W(CNT_W)) u_bounds (
    .off_i   (pkt_off_i),
    .cnt_i   (cnt_i),
    .len_i   (pkt_len_i),
    .oob_o   (span_oob),
    .empty_o (span_empty)
  );

  assign busy_o      = (state_q == ST_WALK);
  assign accept      = start_i && !busy_o;
  assign instant_end = accept && (span_oob || span_empty);
  assign byte_diff   = busy_o && bytes_differ(prog_rd_data_i, pkt_rd_data_i);
  assign walk_end    = busy_o && (byte_diff || last_byte);
  assign finish      = instant_end || walk_end;
  assign fin_mis     = walk_end && byte_diff;
  assign fin_oob     = instant_end && span_oob;

  assign end_sum  = SUM_W'(lit_addr_i) + SUM_W'(cnt_i);
  assign next_c   = end_sum[PROG_AW-1:0];
  assign fin_next = busy_o ? next_q : next_c;

  seqcmp_walker #(.PROG_AW(PROG_AW), .OFF_W(OFF_W), .CNT_W(CNT_W)) u_walker (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (accept && !instant_end),
    .step_i      (busy_o && !walk_end),
    .lit_i       (lit_addr_i),
    .off_i       (pkt_off_i),
    .cnt_i       (cnt_i),
    .prog_addr_o (prog_rd_addr_o),
    .pkt_addr_o  (pkt_rd_addr_o),
    .last_o      (last_byte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      next_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept && !instant_end) begin
          state_q <= ST_WALK;
          next_q  <= next_c;
        end
        ST_WALK: if (walk_end) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  seqcmp_result #(.PROG_AW(PROG_AW)) u_result (
    .clk         (clk),
    .rst_n       (rst_n),
    .finish_i    (finish),
    .mis_i       (fin_mis),
    .oob_i       (fin_oob),
    .next_i      (fin_next),
    .done_o      (done_o),
    .mismatch_o  (mismatch_o),
    .oob_o       (oob_o),
    .next_addr_o (next_addr_o)
  );

  // R4
  stop_on_diff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_diff |=> done_o && mismatch_o && !busy_o);

  // R3
  match_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && last_byte && !byte_diff |=> done_o && !mismatch_o && !oob_o);

  // R5
  oob_no_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && oob_o |-> !$past(busy_o) && !mismatch_o);

  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i && !walk_end |=> busy_o && $stable(next_q));

  // R9
  done_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o));

endmodule

// File: tb/seqcmp_unit_tb.sv
module seqcmp_unit_tb;
  localparam int PROG_AW = 10;
  localparam int OFF_W   = 32;
  localparam int CNT_W   = 16;
  localparam int PDEPTH  = 1 << PROG_AW;
  localparam int KDEPTH  = 1024;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               start_i = 1'b0;
  logic [PROG_AW-1:0] lit_addr_i = '0;
  logic [OFF_W-1:0]   pkt_off_i = '0;
  logic [CNT_W-1:0]   cnt_i = '0;
  logic [OFF_W-1:0]   pkt_len_i = '0;
  logic [PROG_AW-1:0] prog_rd_addr_o;
  logic [7:0]         prog_rd_data_i;
  logic [OFF_W-1:0]   pkt_rd_addr_o;
  logic [7:0]         pkt_rd_data_i;
  logic busy_o, done_o, mismatch_o, oob_o;
  logic [PROG_AW-1:0] next_addr_o;

  logic [7:0] prog_mem [PDEPTH];
  logic [7:0] pkt_mem  [KDEPTH];

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  assign prog_rd_data_i = prog_mem[prog_rd_addr_o];
  assign pkt_rd_data_i  = pkt_mem[pkt_rd_addr_o[9:0]];

  seqcmp_unit #(.PROG_AW(PROG_AW), .OFF_W(OFF_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .lit_addr_i(lit_addr_i),
    .pkt_off_i(pkt_off_i), .cnt_i(cnt_i), .pkt_len_i(pkt_len_i),
    .prog_rd_addr_o(prog_rd_addr_o), .prog_rd_data_i(prog_rd_data_i),
    .pkt_rd_addr_o(pkt_rd_addr_o), .pkt_rd_data_i(pkt_rd_data_i),
    .busy_o(busy_o), .done_o(done_o), .mismatch_o(mismatch_o),
    .oob_o(oob_o), .next_addr_o(next_addr_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Bench-side model: outcome and latency of one request
  function automatic void predict(input int lit, input longint off, input int n,
                                  input longint len, output bit e_oob,
                                  output bit e_mis, output int e_lat);
    e_oob = 0; e_mis = 0; e_lat = n + 1;
    if (off + longint'(n) > len) begin
      e_oob = 1; e_lat = 1;
    end else if (n == 0) begin
      e_lat = 1;
    end else begin
      for (int i = 0; i < n; i++) begin
        if (prog_mem[(lit + i) % PDEPTH] != pkt_mem[int'(off) + i]) begin
          e_mis = 1; e_lat = i + 2; break;
        end
      end
    end
  endfunction

  task automatic run_case(input int lit, input longint off, input int n,
                          input longint len, input bit inject);
    bit e_oob, e_mis;
    int e_lat, cyc;
    string rq;
    logic [PROG_AW-1:0] e_next;
    predict(lit, off, n, len, e_oob, e_mis, e_lat);
    e_next = PROG_AW'(lit + n);
    rq = e_oob ? "R5" : (n == 0) ? "R6" : e_mis ? "R4" : "R3";
    @(negedge clk);
    lit_addr_i = PROG_AW'(lit); pkt_off_i = OFF_W'(off);
    cnt_i = CNT_W'(n); pkt_len_i = OFF_W'(len); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cyc = 1;
    while (!done_o && cyc < 100) begin
      check(busy_o === 1'b1, "R9", "busy during walk", busy_o, 1);
      check(prog_rd_addr_o == PROG_AW'(lit + cyc - 1), "R2", "prog addr",
            prog_rd_addr_o, (lit + cyc - 1) % PDEPTH);
      check(pkt_rd_addr_o == OFF_W'(off + cyc - 1), "R2", "pkt addr",
            pkt_rd_addr_o, off + cyc - 1);
      if (inject && cyc == 3) begin
        start_i = 1'b1; lit_addr_i = '0; pkt_off_i = '0; cnt_i = '0;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start_i = 1'b0;
    check(cyc == e_lat, inject ? "R8" : rq, "done latency", cyc, e_lat);
    check(mismatch_o === e_mis, inject ? "R8" : rq, "mismatch", mismatch_o, e_mis);
    check(oob_o === e_oob, rq, "oob", oob_o, e_oob);
    check(busy_o === 1'b0, "R9", "busy at done", busy_o, 0);
    check(next_addr_o == e_next, "R7", "next addr", next_addr_o, e_next);
    @(negedge clk);
    check(done_o === 1'b0, "R9", "done one cycle", done_o, 0);
    check(next_addr_o == e_next && mismatch_o === e_mis, "R7", "result held",
          next_addr_o, e_next);
  endtask

  task automatic fill_lits(input int lit, input int off, input int n,
                           input int bad);
    for (int i = 0; i < n; i++)
      prog_mem[(lit + i) % PDEPTH] = pkt_mem[off + i];
    if (bad >= 0)
      prog_mem[(lit + bad) % PDEPTH] ^= 8'(1 + ($urandom % 255));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    for (int i = 0; i < PDEPTH; i++) prog_mem[i] = 8'($urandom);
    for (int i = 0; i < KDEPTH; i++) pkt_mem[i] = 8'($urandom);

    repeat (3) @(negedge clk);
    check(done_o === 0 && busy_o === 0, "R1", "done/busy after reset", done_o, 0);
    check(mismatch_o === 0 && oob_o === 0, "R1", "flags after reset", mismatch_o, 0);
    check(next_addr_o === '0, "R1", "next addr after reset", next_addr_o, 0);
    rst_n = 1'b1;

    // Directed corners
    fill_lits(100, 10, 8, -1);   run_case(100, 10, 8, 200, 0);   // R3 full match
    fill_lits(200, 20, 8, 0);    run_case(200, 20, 8, 200, 0);   // R4 first byte
    fill_lits(300, 30, 8, 7);    run_case(300, 30, 8, 200, 0);   // R4 last byte
    fill_lits(1020, 40, 9, -1);  run_case(1020, 40, 9, 200, 0);  // R7 wrap
    run_case(5, 0, 0, 64, 0);                                    // R6 zero count
    fill_lits(400, 56, 8, -1);   run_case(400, 56, 8, 64, 0);    // R5 exact end
    run_case(400, 57, 8, 64, 0);                                 // R5 one past end
    run_case(7, 64'hFFFF_FFF8, 16, 1024, 0);                     // R5 large offset
    fill_lits(500, 100, 12, -1); run_case(500, 100, 12, 600, 1); // R8 start ignored

    // Constrained random
    for (int t = 0; t < 300; t++) begin
      int len, n, off, lit, kind, bad;
      len  = 64 + int'($urandom % (KDEPTH - 63));
      n    = 1 + int'($urandom % 24);
      kind = int'($urandom % 8);
      lit  = int'($urandom % PDEPTH);
      if (kind == 0) n = 0;
      off = int'($urandom % (len - n + 1));
      if (kind == 1) off = len - n + 1 + int'($urandom % 8);
      if (kind == 2) off = len - n;
      bad = ($urandom % 2 == 0 && n > 0) ? int'($urandom % n) : -1;
      if (kind != 1) fill_lits(lit, off, n, bad);
      run_case(lit, longint'(off), n, longint'(len), (kind == 3 && n >= 4) ? 1'b1 : 1'b0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule